// File: doc/BRIEF.md
# Shared-Memory Word Queue Engine

This block keeps a set of word FIFOs that all sit in one shared on-chip memory. Each queue is set up at run time by a single packed configuration word. That word places the queue's storage at a page-aligned base and picks one of four lengths. It also holds two 3-bit watermark codes that shape the queue's fill-level flags. The engine keeps a write pointer, a read pointer and a fill count for every queue. It turns a push on the access port into a memory write at the tail, and a pop into a memory read at the head.

Every queue drives a 4-bit status nibble, so a consumer can poll fill state without popping. The lower half of the queues also keep a sticky overflow flag. A pop of a queue that holds nothing returns zero, so software can drain a queue by reading until it sees zero. Queue setup, push, pop and overflow clearing may all fall in the same clock cycle.

Top module: `shq_engine`

## Requirements
- R1: Configuration word layout. Bits 25:24 hold the length code: 0 gives 16 words, 1 gives 32, 2 gives 64 and 3 gives 128. Bits 21:14 hold the base in 16-word pages. A queue's storage is the words from base×16 upward, modulo the memory size. Writing a configuration word restarts that queue: it becomes empty and its overflow flag clears.
- R2: Words leave a queue in the order they entered it. The popped word appears on `pop_data` in the cycle after the pop request, and `pop_data` is zero in any cycle that follows no successful pop.
- R3: The read pointer and the write pointer each wrap modulo the queue length. A queue therefore keeps working through any number of fill and drain rounds.
- R4: A pop of an empty queue returns zero and changes nothing.
- R5: A queue whose configuration word is zero is unallocated. Pushes to it are ignored and set no overflow, and pops from it return zero.
- R6: Each queue's status nibble is bit0 empty, bit1 nearly empty, bit2 nearly full and bit3 full. It reflects the state after the last clock edge. Out of reset every queue reads 4'b0011.
- R7: Bits 28:26 hold the nearly-empty code and bits 31:29 the nearly-full code. Each code maps to a threshold of 0, 1, 2, 4, 8, 16, 32 or 64 entries for codes 0 to 7. Nearly empty is set when count ≤ threshold. Nearly full is set when (length − count) ≤ threshold.
- R8: A push to a full, allocated queue is dropped and the queue stays full. For queues numbered below NQ/2 this also sets that queue's sticky overflow flag. The upper queues have no overflow flag.
- R9: Bit i of `ovf_clear`, when high, clears overflow flag i. If a dropped push on the same queue falls in the same cycle, the set wins.
- R10: A push and a pop to the same queue in the same cycle both act, judged on the state before the edge. On an empty queue the pop returns zero and the push is stored. On a full queue the pop succeeds and the push is dropped.
- R11: A configuration write to a queue wins over a push or pop to that queue in the same cycle. The push is not stored, and the pop returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | QW | Queue selected by the configuration write |
| cfg_wdata | input | 32 | Packed configuration word |
| push_valid | input | 1 | Push request |
| push_qid | input | QW | Queue to push into |
| push_data | input | DW | Word to push |
| pop_valid | input | 1 | Pop request |
| pop_qid | input | QW | Queue to pop from |
| pop_data | output | DW | Popped word, one cycle after the request; zero otherwise |
| q_status | output | 4*NQ | Status nibble of queue i at bits 4i+3:4i |
| ovf_status | output | NQ/2 | Sticky overflow flags of the lower queues |
| ovf_clear | input | NQ/2 | Write-one-to-clear for the overflow flags |

## Verification
The assertions check several rules on every cycle. A configuration write leaves the queue empty, and the count never exceeds the length. An unallocated queue stays empty. A same-cycle push and pop leave the count unchanged. A dropped push keeps the queue full and raises overflow, the flag stays set until cleared, and a pop of an empty queue yields zero. Only the bench scenarios can show the rest: that data comes back in order across pointer wrap, that the watermark thresholds land at the stated counts for every code, and that separate bases keep queue contents apart. The bench also shows the priority of a configuration write over traffic in the same cycle.

// File: rtl/shq_pkg.sv
package shq_pkg;

  // status nibble: {full, nearly_full, nearly_empty, empty}
  typedef logic [3:0] qstat_t;

  localparam int ST_EMPTY  = 0;
  localparam int ST_NEMPTY = 1;
  localparam int ST_NFULL  = 2;
  localparam int ST_FULL   = 3;

  // queue length in words from the 2-bit length code
  function automatic logic [7:0] qlen(input logic [1:0] code);
    return 8'd16 << code;
  endfunction

  // watermark threshold in entries from a 3-bit code
  function automatic logic [7:0] wm_thresh(input logic [2:0] code);
    if (code == 3'd0) return 8'd0;
    return 8'd1 << (code - 3'd1);
  endfunction

  // pointer increment wrapped modulo the queue length
  function automatic logic [6:0] ptr_inc(input logic [6:0] p, input logic [7:0] len);
    return (p + 7'd1) & 7'(len - 8'd1);
  endfunction

endpackage

// File: rtl/shq_sram.sv
module shq_sram #(
  parameter int DW    = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/shq_queue_ctrl.sv
module shq_queue_ctrl
  import shq_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          push_drop,
  output logic          pop_ok,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output qstat_t        status
);

  logic [31:0] cfg_q;
  logic [7:0]  cnt_q;
  logic [6:0]  wp_q, rp_q;

  logic       alloc;
  logic [7:0] len, free_cnt, thr_ne, thr_nf;
  logic [7:0] base;
  logic       is_full, is_empty;

  assign alloc    = |cfg_q;
  assign len      = qlen(cfg_q[25:24]);
  assign base     = cfg_q[21:14];
  assign thr_ne   = wm_thresh(cfg_q[28:26]);
  assign thr_nf   = wm_thresh(cfg_q[31:29]);
  assign is_full  = (cnt_q == len);
  assign is_empty = (cnt_q == 8'd0);
  assign free_cnt = len - cnt_q;

  // traffic events, all judged on the state before the edge
  assign push_ok   = push_req & alloc & ~is_full  & ~cfg_we;
  assign push_drop = push_req & alloc &  is_full  & ~cfg_we;
  assign pop_ok    = pop_req  & alloc & ~is_empty & ~cfg_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_wdata;
      cnt_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
    end else begin
      if (push_ok) wp_q <= ptr_inc(wp_q, len);
      if (pop_ok)  rp_q <= ptr_inc(rp_q, len);
      cnt_q <= cnt_q + 8'(push_ok) - 8'(pop_ok);
    end
  end

  assign wr_addr = AW'({base, 4'b0000}) + AW'(wp_q);
  assign rd_addr = AW'({base, 4'b0000}) + AW'(rp_q);

  always_comb begin
    status            = '0;
    status[ST_EMPTY]  = is_empty;
    status[ST_NEMPTY] = (cnt_q <= thr_ne);
    status[ST_NFULL]  = (free_cnt <= thr_nf);
    status[ST_FULL]   = is_full;
  end

  // R1: a configuration write restarts the queue
  a_r1_cfg_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cnt_q == 8'd0));

  // R6: the count never exceeds the queue length
  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= len);

  // R5: an unallocated queue stays empty
  a_r5_unalloc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc && !cfg_we) |=> (cnt_q == 8'd0));

  // R10: an accepted push and pop in one cycle keep the count
  a_r10_both_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(cnt_q));

  // R8: a dropped push leaves a full queue full
  a_r8_full_drop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_req) |=> is_full);

  // R4: a pop of an empty queue changes nothing
  a_r4_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && is_empty && !push_req && !cfg_we) |=> (cnt_q == 8'd0));

endmodule

// File: rtl/shq_ovf_flag.sv
module shq_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_clr,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (cfg_clr) flag <= 1'b0;
    else if (set)     flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  // R8: a dropped push raises the flag
  a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  // R9: the flag is sticky until cleared
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr && !cfg_clr) |=> flag);

  // R9: write-one-to-clear takes effect when no set competes
  a_r9_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);

endmodule

// File: rtl/shq_engine.sv
module shq_engine
  import shq_pkg::*;
#(
  parameter int NQ        = 8,
  parameter int DW        = 32,
  parameter int MEM_WORDS = 1024,
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int OVQ = NQ / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [QW-1:0]   cfg_qid,
  input  logic [31:0]     cfg_wdata,
  input  logic            push_valid,
  input  logic [QW-1:0]   push_qid,
  input  logic [DW-1:0]   push_data,
  input  logic            pop_valid,
  input  logic [QW-1:0]   pop_qid,
  output logic [DW-1:0]   pop_data,
  output logic [4*NQ-1:0] q_status,
  output logic [OVQ-1:0]  ovf_status,
  input  logic [OVQ-1:0]  ovf_clear
);

  localparam int AW = $clog2(MEM_WORDS);

  logic [NQ-1:0] push_ok_v, push_drop_v, pop_ok_v;
  logic [AW-1:0] wa_v [NQ];
  logic [AW-1:0] ra_v [NQ];
  qstat_t        stat_v [NQ];

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic cfg_hit, push_hit, pop_hit;
    assign cfg_hit  = cfg_we     && (cfg_qid  == QW'(i));
    assign push_hit = push_valid && (push_qid == QW'(i));
    assign pop_hit  = pop_valid  && (pop_qid  == QW'(i));

    shq_queue_ctrl #(.AW(AW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_hit),
      .cfg_wdata (cfg_wdata),
      .push_req  (push_hit),
      .pop_req   (pop_hit),
      .push_ok   (push_ok_v[i]),
      .push_drop (push_drop_v[i]),
      .pop_ok    (pop_ok_v[i]),
      .wr_addr   (wa_v[i]),
      .rd_addr   (ra_v[i]),
      .status    (stat_v[i])
    );

    assign q_status[4*i +: 4] = stat_v[i];

    if (i < OVQ) begin : g_ovf
      shq_ovf_flag u_ovf (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_clr (cfg_hit),
        .set     (push_drop_v[i]),
        .clr     (ovf_clear[i]),
        .flag    (ovf_status[i])
      );
    end
  end

  logic [DW-1:0] rdata;
  logic          rd_en_q;

  shq_sram #(.DW(DW), .DEPTH(MEM_WORDS)) u_mem (
    .clk   (clk),
    .we    (|push_ok_v),
    .waddr (wa_v[push_qid]),
    .wdata (push_data),
    .re    (|pop_ok_v),
    .raddr (ra_v[pop_qid]),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_en_q <= 1'b0;
    else        rd_en_q <= |pop_ok_v;
  end

  assign pop_data = rd_en_q ? rdata : '0;

  // R4: a pop of an empty queue yields zero on the next cycle
  a_r4_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && stat_v[pop_qid][ST_EMPTY]) |=> (pop_data == '0));

  // R8: a dropped push (no pop on that queue) leaves the queue flagged full
  a_r8_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_drop_v[push_qid] && !(pop_valid && pop_qid == push_qid))
      |=> stat_v[$past(push_qid)][ST_FULL]);

  // R2: no pop accepted means zero data next cycle
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pop_ok_v) |=> (pop_data == '0));

endmodule

// File: tb/test_shq_engine.sv
`timescale 1ns/1ps
module test_shq_engine;
  localparam int NQ = 8;
  localparam int OVQ = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_qid = 0; logic [31:0] cfg_wdata = 0;
  logic push_valid = 0; logic [2:0] push_qid = 0; logic [31:0] push_data = 0;
  logic pop_valid = 0; logic [2:0] pop_qid = 0;
  logic [31:0] pop_data;
  logic [4*NQ-1:0] q_status;
  logic [OVQ-1:0] ovf_status;
  logic [OVQ-1:0] ovf_clear = 0;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  shq_engine i_shq_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_wdata(cfg_wdata),
    .push_valid(push_valid), .push_qid(push_qid), .push_data(push_data),
    .pop_valid(pop_valid), .pop_qid(pop_qid), .pop_data(pop_data),
    .q_status(q_status), .ovf_status(ovf_status), .ovf_clear(ovf_clear));

  // reference model
  logic [31:0] m_mem [NQ][128];
  logic [31:0] m_cfg [NQ];
  int m_head [NQ];
  int m_cnt [NQ];
  bit m_ovf [NQ];

  function automatic int m_len(int q);
    return 16 * (1 << m_cfg[q][25:24]);
  endfunction

  function automatic int thr_tab(logic [2:0] c);
    case (c)
      3'd0: return 0;  3'd1: return 1;  3'd2: return 2;  3'd3: return 4;
      3'd4: return 8;  3'd5: return 16; 3'd6: return 32; default: return 64;
    endcase
  endfunction

  function automatic logic [3:0] exp_stat(int q);
    int len, c;
    len = m_len(q); c = m_cnt[q];
    return {c == len, (len - c) <= thr_tab(m_cfg[q][31:29]),
            c <= thr_tab(m_cfg[q][28:26]), c == 0};
  endfunction

  function automatic logic [31:0] mk_cfg(int base, int code, int ne, int nf);
    return (32'(nf) << 29) | (32'(ne) << 26) | (32'(code) << 24) | (32'(base) << 14);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int q = 0; q < NQ; q++)
      chk(q_status[4*q +: 4] == exp_stat(q), req, 32'(q_status[4*q +: 4]), 32'(exp_stat(q)));
    for (int q = 0; q < OVQ; q++)
      chk(ovf_status[q] == m_ovf[q], req, 32'(ovf_status[q]), 32'(m_ovf[q]));
  endtask

  task automatic op(bit cw, int cq, logic [31:0] cd, bit pu, int pq, logic [31:0] pd,
                    bit po, int oq, logic [3:0] clr, string req);
    logic [31:0] exp_pop;
    bit pop_m, push_m, drop_m, pcoll;
    int len;
    @(negedge clk);
    cfg_we = cw; cfg_qid = 3'(cq); cfg_wdata = cd;
    push_valid = pu; push_qid = 3'(pq); push_data = pd;
    pop_valid = po; pop_qid = 3'(oq); ovf_clear = clr;
    pop_m = po && m_cfg[oq] != 0 && m_cnt[oq] > 0 && !(cw && cq == oq);
    exp_pop = pop_m ? m_mem[oq][m_head[oq]] : 32'd0;
    pcoll = cw && cq == pq;
    len = m_len(pq);
    push_m = pu && m_cfg[pq] != 0 && m_cnt[pq] < len && !pcoll;
    drop_m = pu && m_cfg[pq] != 0 && m_cnt[pq] == len && !pcoll;
    @(posedge clk); #1;
    cfg_we = 0; push_valid = 0; pop_valid = 0; ovf_clear = 0;
    if (po) chk(pop_data == exp_pop, req, pop_data, exp_pop);
    else    chk(pop_data == 32'd0, "R2", pop_data, 32'd0);
    if (push_m) begin
      m_mem[pq][(m_head[pq] + m_cnt[pq]) % len] = pd;
      m_cnt[pq]++;
    end
    if (pop_m) begin
      m_head[oq] = (m_head[oq] + 1) % m_len(oq);
      m_cnt[oq]--;
    end
    for (int q = 0; q < OVQ; q++)
      m_ovf[q] = (m_ovf[q] && !clr[q]) || (drop_m && pq == q);
    if (cw) begin
      m_cfg[cq] = cd; m_cnt[cq] = 0; m_head[cq] = 0;
      if (cq < OVQ) m_ovf[cq] = 0;
    end
    check_all(req);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    for (int q = 0; q < NQ; q++) begin
      m_cfg[q] = 0; m_cnt[q] = 0; m_head[q] = 0; m_ovf[q] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R6: reset state
    for (int q = 0; q < NQ; q++)
      chk(q_status[4*q +: 4] == 4'b0011, "R6", 32'(q_status[4*q +: 4]), 32'h3);
    chk(ovf_status == 0, "R6", 32'(ovf_status), 0);
    chk(pop_data == 0, "R2", pop_data, 0);

    // R5: unallocated queue ignores push, pops zero
    op(0,0,0, 1,0,32'hdead_beef, 0,0,4'h0, "R5");
    op(0,0,0, 0,0,0, 1,0,4'h0, "R5");

    // R1: configure every queue at its own base
    for (int q = 0; q < NQ; q++)
      op(1,q,mk_cfg(q*8, q%4, (q+1)%8, (q+2)%8), 0,0,0, 0,0,4'h0, "R1");

    // R4: pop of an empty allocated queue
    op(0,0,0, 0,0,0, 1,1,4'h0, "R4");

    // R7/R6: fill queue 0 (16 words) step by step
    for (int k = 0; k < 16; k++)
      op(0,0,0, 1,0,32'h100 + k, 0,0,4'h0, "R7");
    // R8: push to full queue is dropped, overflow set
    op(0,0,0, 1,0,32'hbad0, 0,0,4'h0, "R8");
    // R10: push+pop on a full queue: pop succeeds, push dropped
    op(0,0,0, 1,0,32'hbad1, 1,0,4'h0, "R10");
    // R9: clear and set in one cycle: set wins
    op(0,0,0, 1,0,32'h200, 0,0,4'h1, "R9");
    op(0,0,0, 1,0,32'hbad2, 0,0,4'h1, "R9");
    op(0,0,0, 0,0,0, 0,0,4'h1, "R9");
    // R8: upper queue 4 (16 words) fills, drop keeps it full
    for (int k = 0; k < 17; k++)
      op(0,0,0, 1,4,32'h400 + k, 0,0,4'h0, "R8");
    // R2: drain queue 0 in order, then R4 extra pop
    for (int k = 0; k < 17; k++)
      op(0,0,0, 0,0,0, 1,0,4'h0, "R2");
    // R10: push and pop on an empty queue
    op(0,0,0, 1,3,32'h33, 1,3,4'h0, "R10");
    op(0,0,0, 0,0,0, 1,3,4'h0, "R10");
    // R11: configuration write beats a push and a pop
    op(0,0,0, 1,2,32'h22, 0,0,4'h0, "R11");
    op(1,2,mk_cfg(16,2,3,3), 1,2,32'h23, 1,2,4'h0, "R11");
    op(0,0,0, 0,0,0, 1,2,4'h0, "R11");
    // R1: reconfigure clears overflow
    for (int k = 0; k < 17; k++)
      op(0,0,0, 1,0,32'h500 + k, 0,0,4'h0, "R8");
    op(1,0,mk_cfg(0,0,1,2), 0,0,0, 0,0,4'h0, "R1");

    // R3: random traffic, pointers wrap many times
    for (int n = 0; n < 6000; n++) begin
      bit pu, po, cw;
      int pq, oq;
      pq = int'($urandom % NQ); oq = int'($urandom % NQ);
      pu = ((n / 500) % 2 == 0) ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
      po = ((n / 500) % 2 == 0) ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
      cw = ($urandom % 400 == 0);
      op(cw, oq, m_cfg[oq], pu, pq, $urandom, po, oq,
         ($urandom % 16 == 0) ? 4'($urandom) : 4'h0, "R3");
    end
    // R2: final drain of every queue
    for (int q = 0; q < NQ; q++)
      for (int k = 0; k < 130; k++)
        op(0,0,0, 0,0,0, 1,q,4'h0, "R2");
    finish_run();
  end
endmodule